// File: doc/BRIEF.md
# Serial Control-Word Receiver

This block takes configuration bytes from a slow asynchronous serial line and loads them into a small bank of setting registers. A mode decoder then turns the main register into the mode outputs that steer the rest of the front end. The line runs at one bit per 32 cycles of the tape clock. Each byte is framed by a low start bit and a high stop bit. The receiver starts its bit timer on the falling edge of the start bit and samples every bit at its midpoint.

Control bits can reach the block in two ways. The first is a dedicated control pin. The second applies when that pin is held low for longer than any legal byte could keep it low: the block then takes one bit per 32-clock record frame from a fixed time-slot of the record data stream. Those slot bits form a second serial line with the same framing.

After reset the receiver accepts nothing until it has seen ten full bit periods of uninterrupted high level. Each accepted byte carries a 2-bit register selector in its first two payload bits and a 6-bit value in the remaining six. The value loads the selected register in a single cycle, and only after a valid stop bit.

Top module: `ctlword_rx`

## Requirements
- R1: A byte is one low start bit, eight payload bits sent least significant first, and one high stop bit, each lasting 32 clocks. Each bit is sampled 16 clocks after its leading edge, timed from the detected start-bit falling edge.
- R2: After synchronous active-low reset, register 0 holds 6'b000110 and registers 1 to 3 hold 0. `cfg_regs` bits [6*i+5:6*i] hold register i. The outputs read acc_mode=0, agc_en=1, fecr_hi=0, extclk_sel=0, search_en=0 and cutoff_sel=2'b11.
- R3: After reset, no byte is accepted until the active line has been high for 320 consecutive clocks. Any low level before that restarts the count.
- R4: A byte whose stop bit samples low changes no register. The receiver returns to idle and accepts the next correctly framed byte.
- R5: Payload bits [1:0] select register 0 to 3, and payload bits [7:2] become that register's value. No other register changes.
- R6: When the control pin stays low for 384 consecutive clocks, the active line becomes a held copy of `rec_data`. The copy is taken once per frame, at frame position 3, where position 0 is the cycle in which `rec_frame` is high. A high level on the control pin returns control to the pin.
- R7: A low pulse on the active line that is shorter than half a bit makes the receiver treat the start bit as false, and no register changes.
- R8: The mode outputs come from register 0 as follows:
  - acc_mode = bit 0
  - cutoff_sel = bits [2:1]
  - extclk_sel = bit 3
  - fecr_hi = bit 4
  - agc_en = !bit0 && !bit4
  - search_en = bit 5 && !bit 3, so the external-clock selection wins when both bits are set.
- R9: A reset asserted during operation restores the standby register values and re-arms the 320-clock initialisation rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tape clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_pin | input | 1 | Dedicated asynchronous control line, idle high |
| rec_data | input | 1 | Record data stream carrying the embedded control slot |
| rec_frame | input | 1 | High in position 0 of each 32-clock record frame |
| cfg_regs | output | 24 | Four 6-bit setting registers, register i at bits [6*i+5:6*i] |
| acc_mode | output | 1 | Analog-cassette playback selected |
| agc_en | output | 1 | Automatic gain control enabled (digital mode only) |
| fecr_hi | output | 1 | Ferro/chrome switch level |
| extclk_sel | output | 1 | Filter clock taken from the external pin |
| search_en | output | 1 | Music-search detector enabled |
| cutoff_sel | output | 2 | AC-coupling cut-off frequency selection |

## Verification
The bench writes bytes with mixed bit patterns to every register, so that a swapped selector, a wrong bit order or a write leaking into a neighbour shows up as a wrong value. Framing faults are tried with a low stop bit and with a short glitch on the line; these separate a receiver that validates the stop and start samples from one that trusts the edge alone. The initialisation rule is probed with a byte sent after too short an idle period, both at power-up and after a mid-run reset. A byte sent through the embedded frame slot, followed by a byte on the pin again, shows whether source switching honours the hold-low threshold and the slot position. Several register-0 values separate the decoder's priority and masking terms.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;

   // bit positions inside the mode register (register 0)
   localparam int MB_ACC    = 0;
   localparam int MB_CUT_LO = 1;
   localparam int MB_CUT_HI = 2;
   localparam int MB_EXTCLK = 3;
   localparam int MB_AGCOFF = 4;
   localparam int MB_SEARCH = 5;
   localparam int MODE_BITS = 6;

endpackage

// File: rtl/ctlrx_srcsel.sv
module ctlrx_srcsel #(
   parameter int BIT_CYC     = 32,
   parameter int SLOT_POS    = 3,
   parameter int HOLD_CYC    = 384,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_pin,
   input  logic rec_data,
   input  logic rec_frame,
   output logic line,
   output logic emb_mode
);
   localparam int POS_W  = $clog2(BIT_CYC);
   localparam int HOLD_W = $clog2(HOLD_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctlrx_srcsel: SYNC_STAGES must be at least 2");
      end
      if ((1 << POS_W) != BIT_CYC) begin : g_bad_bitcyc
         $error("ctlrx_srcsel: BIT_CYC must be a power of two");
      end
      if (SLOT_POS >= BIT_CYC) begin : g_bad_slot
         $error("ctlrx_srcsel: SLOT_POS outside the frame");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic [HOLD_W-1:0]      low_cnt;
   logic                   emb_q;
   logic [POS_W-1:0]       fpos;
   logic [POS_W-1:0]       cur_pos;
   logic                   emb_line;

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ctl_pin};
   end

   // hold-low detector choosing the embedded source
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         emb_q   <= 1'b0;
      end else if (pin_s) begin
         low_cnt <= '0;
         emb_q   <= 1'b0;
      end else begin
         if (low_cnt != HOLD_W'(HOLD_CYC)) low_cnt <= low_cnt + 1'b1;
         if (low_cnt == HOLD_W'(HOLD_CYC - 1)) emb_q <= 1'b1;
      end
   end

   // frame position tracker and slot capture
   assign cur_pos = rec_frame ? '0 : fpos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpos     <= '0;
         emb_line <= 1'b1;
      end else begin
         fpos <= cur_pos + 1'b1;
         if (cur_pos == POS_W'(SLOT_POS)) emb_line <= rec_data;
      end
   end

   assign emb_mode = emb_q;
   assign line     = emb_q ? emb_line : pin_s;

   assert_emb_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (emb_q && pin_s) |=> !emb_q)
      else $error("embedded mode kept after pin went high");

endmodule

// File: rtl/ctlrx_framer.sv
module ctlrx_framer
   import ctlrx_pkg::*;
#(
   parameter int BIT_CYC   = 32,
   parameter int INIT_BITS = 10,
   parameter int PAY_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line,
   output logic             commit,
   output logic [PAY_W-1:0] payload
);
   localparam int HALF     = BIT_CYC / 2;
   localparam int INIT_CYC = BIT_CYC * INIT_BITS;
   localparam int PH_W     = $clog2(BIT_CYC);
   localparam int IDX_W    = $clog2(PAY_W + 1);
   localparam int INIT_W   = $clog2(INIT_CYC + 1);

   generate
      if (BIT_CYC < 4) begin : g_bad_bit
         $error("ctlrx_framer: BIT_CYC too small");
      end
      if (INIT_BITS < 1) begin : g_bad_init
         $error("ctlrx_framer: INIT_BITS must be positive");
      end
   endgenerate

   rx_state_t          state;
   logic               line_d;
   logic [INIT_W-1:0]  ok_cnt;
   logic               armed;
   logic [PH_W-1:0]    phase;
   logic [IDX_W-1:0]   idx;
   logic [PAY_W-1:0]   shreg;
   logic               commit_q;
   logic               mid;

   assign mid = (phase == PH_W'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_d   <= 1'b1;
         ok_cnt   <= '0;
         armed    <= 1'b0;
         state    <= RX_IDLE;
         phase    <= '0;
         idx      <= '0;
         shreg    <= '0;
         commit_q <= 1'b0;
      end else begin
         line_d   <= line;
         commit_q <= 1'b0;

         // power-up initialisation: a run of high level
         if (!armed) begin
            if (!line) ok_cnt <= '0;
            else if (ok_cnt == INIT_W'(INIT_CYC - 1)) armed <= 1'b1;
            else ok_cnt <= ok_cnt + 1'b1;
         end

         if (state != RX_IDLE)
            phase <= (phase == PH_W'(BIT_CYC - 1)) ? '0 : phase + 1'b1;

         case (state)
            RX_IDLE: begin
               if (armed && line_d && !line) begin
                  state <= RX_START;
                  phase <= '0;
               end
            end
            RX_START: begin
               if (mid) begin
                  if (line) state <= RX_IDLE;
                  else begin
                     state <= RX_DATA;
                     idx   <= '0;
                  end
               end
            end
            RX_DATA: begin
               if (mid) begin
                  shreg <= {line, shreg[PAY_W-1:1]};
                  if (idx == IDX_W'(PAY_W - 1)) state <= RX_STOP;
                  else idx <= idx + 1'b1;
               end
            end
            RX_STOP: begin
               if (mid) begin
                  state <= RX_IDLE;
                  if (line) commit_q <= 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign commit  = commit_q;
   assign payload = shreg;

   assert_idle_until_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (state == RX_IDLE))
      else $error("receiver left idle before initialisation");

   assert_commit_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> armed)
      else $error("byte committed while not armed");

   assert_commit_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> !commit_q)
      else $error("back-to-back commits");

endmodule

// File: rtl/ctlrx_regbank.sv
module ctlrx_regbank #(
   parameter int N_REGS = 4,
   parameter int PAY_W  = 8,
   parameter int ID_W   = 2,
   parameter int VAL_W  = 6,
   parameter logic [VAL_W-1:0] RST_REG0 = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [PAY_W-1:0]        payload,
   output logic [N_REGS*VAL_W-1:0] regs
);
   generate
      if (ID_W + VAL_W != PAY_W) begin : g_bad_split
         $error("ctlrx_regbank: selector and value must fill the payload");
      end
      if ((1 << ID_W) < N_REGS) begin : g_bad_id
         $error("ctlrx_regbank: selector too narrow for N_REGS");
      end
   endgenerate

   logic [N_REGS-1:0] wr;

   genvar gi;
   generate
      for (gi = 0; gi < N_REGS; gi++) begin : g_reg
         logic [VAL_W-1:0] r;
         assign wr[gi] = commit && (payload[ID_W-1:0] == ID_W'(gi));
         always_ff @(posedge clk) begin
            if (!rst_n)      r <= (gi == 0) ? RST_REG0 : '0;
            else if (wr[gi]) r <= payload[PAY_W-1:ID_W];
         end
         assign regs[gi*VAL_W +: VAL_W] = r;
      end
   endgenerate

   assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr))
      else $error("more than one register written");

   assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs))
      else $error("register changed without a valid byte");

endmodule

// File: rtl/ctlrx_modedec.sv
module ctlrx_modedec
   import ctlrx_pkg::*;
#(
   parameter int VAL_W = 6
) (
   input  logic [VAL_W-1:0] mode,
   output logic             acc_mode,
   output logic             agc_en,
   output logic             fecr_hi,
   output logic             extclk_sel,
   output logic             search_en,
   output logic [1:0]       cutoff_sel
);
   generate
      if (VAL_W < MODE_BITS) begin : g_bad_mode
         $error("ctlrx_modedec: mode register narrower than its fields");
      end
   endgenerate

   always_comb begin
      acc_mode   = mode[MB_ACC];
      cutoff_sel = {mode[MB_CUT_HI], mode[MB_CUT_LO]};
      extclk_sel = mode[MB_EXTCLK];
      fecr_hi    = mode[MB_AGCOFF];
      agc_en     = !mode[MB_ACC] && !mode[MB_AGCOFF];
      // external clock selection overrides the search detector
      search_en  = mode[MB_SEARCH] && !mode[MB_EXTCLK];
   end

   always_comb begin
      assert_no_search_with_extclk_R8: assert (!(search_en && extclk_sel))
         else $error("search detector enabled together with external clock");
   end

endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
   import ctlrx_pkg::*;
#(
   parameter int BIT_CYC     = 32,
   parameter int INIT_BITS   = 10,
   parameter int HOLD_BITS   = 12,
   parameter int SLOT_POS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int N_REGS      = 4,
   parameter int PAY_W       = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          ctl_pin,
   input  logic                                          rec_data,
   input  logic                                          rec_frame,
   output logic [N_REGS*(PAY_W-$clog2(N_REGS))-1:0]      cfg_regs,
   output logic                                          acc_mode,
   output logic                                          agc_en,
   output logic                                          fecr_hi,
   output logic                                          extclk_sel,
   output logic                                          search_en,
   output logic [1:0]                                    cutoff_sel
);
   localparam int ID_W     = $clog2(N_REGS);
   localparam int VAL_W    = PAY_W - ID_W;
   localparam int HOLD_CYC = BIT_CYC * HOLD_BITS;
   localparam logic [VAL_W-1:0] STBY_MODE =
      VAL_W'((1 << MB_CUT_LO) | (1 << MB_CUT_HI));

   generate
      if (HOLD_BITS <= PAY_W + 1) begin : g_bad_hold
         $error("ctlword_rx: hold-low threshold must exceed a zero byte");
      end
   endgenerate

   logic             line;
   logic             emb_mode;
   logic             commit;
   logic [PAY_W-1:0] payload;

   ctlrx_srcsel #(
      .BIT_CYC(BIT_CYC), .SLOT_POS(SLOT_POS),
      .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .rec_data(rec_data),
      .rec_frame(rec_frame), .line(line), .emb_mode(emb_mode)
   );

   ctlrx_framer #(
      .BIT_CYC(BIT_CYC), .INIT_BITS(INIT_BITS), .PAY_W(PAY_W)
   ) u_frm (
      .clk(clk), .rst_n(rst_n), .line(line),
      .commit(commit), .payload(payload)
   );

   ctlrx_regbank #(
      .N_REGS(N_REGS), .PAY_W(PAY_W), .ID_W(ID_W), .VAL_W(VAL_W),
      .RST_REG0(STBY_MODE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .payload(payload),
      .regs(cfg_regs)
   );

   ctlrx_modedec #(.VAL_W(VAL_W)) u_dec (
      .mode(cfg_regs[VAL_W-1:0]),
      .acc_mode(acc_mode), .agc_en(agc_en), .fecr_hi(fecr_hi),
      .extclk_sel(extclk_sel), .search_en(search_en), .cutoff_sel(cutoff_sel)
   );

   assert_line_high_in_emb_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(emb_mode) |-> !commit)
      else $error("commit coincided with source switch");

endmodule

// File: tb/tb_ctlword_rx.sv
`timescale 1ns/1ps
module tb_ctlword_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_pin = 1'b1;
   logic        rec_data = 1'b1;
   logic        rec_frame = 1'b0;
   logic [23:0] cfg_regs;
   logic        acc_mode, agc_en, fecr_hi, extclk_sel, search_en;
   logic [1:0]  cutoff_sel;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   ctlword_rx dut (
      .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .rec_data(rec_data),
      .rec_frame(rec_frame), .cfg_regs(cfg_regs), .acc_mode(acc_mode),
      .agc_en(agc_en), .fecr_hi(fecr_hi), .extclk_sel(extclk_sel),
      .search_en(search_en), .cutoff_sel(cutoff_sel)
   );

   localparam logic [23:0] STBY = 24'h000006;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] regv(input int i);
      return cfg_regs[i*6 +: 6];
   endfunction

   task automatic idle_bits(input int n);
      ctl_pin = 1'b1;
      repeat (n * 32) @(negedge clk);
   endtask

   task automatic pin_bit(input logic b);
      ctl_pin = b;
      repeat (32) @(negedge clk);
   endtask

   task automatic pin_byte(input logic [1:0] id, input logic [5:0] val, input logic stopv);
      logic [7:0] p;
      p = {val, id};
      pin_bit(1'b0);
      for (int k = 0; k < 8; k++) pin_bit(p[k]);
      pin_bit(stopv);
      idle_bits(2);
   endtask

   task automatic emb_frame(input logic b);
      for (int c = 0; c < 32; c++) begin
         rec_frame = (c == 0);
         rec_data  = b;
         @(negedge clk);
      end
      rec_frame = 1'b0;
   endtask

   task automatic emb_byte(input logic [1:0] id, input logic [5:0] val);
      logic [7:0] p;
      p = {val, id};
      emb_frame(1'b0);
      for (int k = 0; k < 8; k++) emb_frame(p[k]);
      emb_frame(1'b1);
      emb_frame(1'b1);
      emb_frame(1'b1);
   endtask

   task automatic t_reset();
      chk("R2 regs", {8'h0, cfg_regs}, {8'h0, STBY});
      chk("R2 acc_mode", acc_mode, 0);
      chk("R2 agc_en", agc_en, 1);
      chk("R2 fecr_hi", fecr_hi, 0);
      chk("R2 extclk_sel", extclk_sel, 0);
      chk("R2 search_en", search_en, 0);
      chk("R2 cutoff_sel", cutoff_sel, 2'b11);
   endtask

   task automatic t_init();
      idle_bits(5);
      pin_byte(2'd1, 6'h2A, 1'b1);           // too early, R3
      chk("R3 early byte ignored", {8'h0, cfg_regs}, {8'h0, STBY});
      idle_bits(11);
      pin_byte(2'd1, 6'h2A, 1'b1);
      chk("R3 byte after init accepted", regv(1), 6'h2A);
   endtask

   task automatic t_write();
      pin_byte(2'd2, 6'h15, 1'b1);
      chk("R5 reg2", regv(2), 6'h15);
      chk("R5 reg1 untouched", regv(1), 6'h2A);
      pin_byte(2'd3, 6'h3F, 1'b1);
      chk("R5 reg3", regv(3), 6'h3F);
      chk("R1 full map", {8'h0, cfg_regs}, {8'h0, 6'h3F, 6'h15, 6'h2A, 6'h06});
      pin_byte(2'd1, 6'h01, 1'b1);
      chk("R1 bit order", regv(1), 6'h01);
   endtask

   task automatic t_badstop();
      pin_byte(2'd1, 6'h33, 1'b0);
      chk("R4 bad stop discarded", regv(1), 6'h01);
      pin_byte(2'd1, 6'h0C, 1'b1);
      chk("R4 next byte accepted", regv(1), 6'h0C);
   endtask

   task automatic t_glitch();
      ctl_pin = 1'b0;
      repeat (4) @(negedge clk);
      idle_bits(3);
      chk("R7 glitch ignored", {8'h0, cfg_regs}, {8'h0, 6'h3F, 6'h15, 6'h0C, 6'h06});
      pin_byte(2'd2, 6'h22, 1'b1);
      chk("R7 recovers after glitch", regv(2), 6'h22);
   endtask

   task automatic t_mode();
      pin_byte(2'd0, 6'b010001, 1'b1);
      chk("R8 acc_mode", acc_mode, 1);
      chk("R8 agc_en off", agc_en, 0);
      chk("R8 fecr_hi", fecr_hi, 1);
      chk("R8 cutoff 00", cutoff_sel, 2'b00);
      pin_byte(2'd0, 6'b101000, 1'b1);
      chk("R8 extclk wins", extclk_sel, 1);
      chk("R8 search masked", search_en, 0);
      pin_byte(2'd0, 6'b100010, 1'b1);
      chk("R8 search on", search_en, 1);
      chk("R8 agc_en on", agc_en, 1);
      chk("R8 cutoff 01", cutoff_sel, 2'b01);
   endtask

   task automatic t_emb();
      ctl_pin = 1'b0;
      for (int f = 0; f < 13; f++) emb_frame(1'b1);
      emb_byte(2'd2, 6'h2D);
      chk("R6 embedded byte", regv(2), 6'h2D);
      chk("R6 other regs kept", regv(3), 6'h3F);
      idle_bits(3);
      pin_byte(2'd3, 6'h11, 1'b1);
      chk("R6 back to pin", regv(3), 6'h11);
   endtask

   task automatic t_rearm();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 standby after reset", {8'h0, cfg_regs}, {8'h0, STBY});
      idle_bits(1);
      pin_byte(2'd1, 6'h3C, 1'b1);
      chk("R9 init re-armed", regv(1), 6'h00);
   endtask

   initial begin
      ctl_pin = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init();
      t_write();
      t_badstop();
      t_glitch();
      t_mode();
      t_emb();
      t_rearm();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails + 1);
      $finish;
   end

endmodule